// File: doc/BRIEF.md
# Bidirectional GPIO Port with Per-Bit Direction

This block is one eight-bit general-purpose I/O port with a small register bus. It holds an output value register and a direction register, each at its own address. For every pin it drives an output-enable and an output value to the pad ring. It also takes the pin input levels and passes them through a two-flop synchronizer.

A read of the value address returns a mix chosen bit by bit. A bit configured as output returns the stored output value, and a bit configured as input returns the synchronized pin level. Software can preload the output value register while a pin is still an input, so the pin drives the new value from the first cycle its driver turns on.

The two top pins have pull-up enables, gated so that a pull-up is active only while its pin is an input. The synchronized levels of pins 0..3 go out to an analog converter, and those of pins 4..5 go out to a timer.

Top module: `gpio_dir_port`

## Requirements
- R1: After reset the direction register and the output value register are both 0x00, so every `pin_oe` bit and every `pin_out` bit is 0.
- R2: A write to address 0x7 loads the direction register on that clock edge. Direction bit 1 means output (`pin_oe` bit high) and 0 means input. A read of 0x7 returns the direction register unchanged.
- R3: A write to address 0x3 loads the output value register whatever the direction bits are. `pin_out` shows that register in the following cycle, including on pins that are currently inputs.
- R4: A read of address 0x3 returns, for each bit, the output value register bit when the direction bit is 1 and the synchronized pin level when it is 0.
- R5: A pin level change reaches the value readback and the side outputs after two clock edges, and not after one.
- R6: `pu_en[k]` (k = 0 for pin 6, k = 1 for pin 7) is high only when `pu_cfg[k]` is high and that pin's direction bit is 0.
- R7: `bus_rdata` is 0x00 when `bus_rd` is low or the address is neither 0x3 nor 0x7. A write to any other address changes neither register.
- R8: `adc_lvl` carries synchronized pins 3..0 and `tmr_lvl` carries synchronized pins 5..4.
- R9: A pin whose output value was preloaded shows that value on `pin_out` in the same cycle its `pin_oe` bit rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe, combinational read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pin_in | input | 8 | Pin input levels (asynchronous) |
| pin_oe | output | 8 | Per-pin output driver enable |
| pin_out | output | 8 | Per-pin output value |
| pu_cfg | input | 2 | Pull-up request for pins 7..6 |
| pu_en | output | 2 | Pull-up enable for pins 7..6 |
| adc_lvl | output | 4 | Synchronized levels of pins 3..0 |
| tmr_lvl | output | 2 | Synchronized levels of pins 5..4 |

## Verification
The properties assume that the address, the strobes and the write data are known and steady around each rising edge. They also assume a write strobe means exactly one register update per cycle in which it is high. The bench changes every bus input and `pin_in` on the falling edge and holds each strobe for exactly one cycle, which keeps it inside those assumptions. Pin levels are checked against the readback only after counting the synchronizer stages, so the properties say nothing about the pin path before that point.

// File: rtl/gpio_dir_pkg.sv
package gpio_dir_pkg;
   typedef enum logic [1:0] {
      RSEL_NONE = 2'd0,
      RSEL_VAL  = 2'd1,
      RSEL_DIR  = 2'd2
   } rsel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      chain[s] <= '0;
         else if (s == 0) chain[s] <= d;
         else             chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             val_we,
   input  logic             dir_we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] val_q,
   output logic [WIDTH-1:0] dir_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      val_q <= '0;
      else if (val_we) val_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= '0;
      else if (dir_we) dir_q <= wdata;
   end
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
   import gpio_dir_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  rsel_e            sel,
   input  logic [WIDTH-1:0] val_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] mixed;

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign mixed[b] = dir_q[b] ? val_q[b] : lvl[b];
   end

   always_comb begin
      unique case (sel)
         RSEL_VAL: rdata = mixed;
         RSEL_DIR: rdata = dir_q;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_dir_port.sv
module gpio_dir_port
   import gpio_dir_pkg::*;
#(
   parameter int          WIDTH       = 8,
   parameter int          ADDR_W      = 4,
   parameter logic [3:0]  VAL_ADDR    = 4'h3,
   parameter logic [3:0]  DIR_ADDR    = 4'h7,
   parameter int          SYNC_STAGES = 2,
   parameter int          PU_LSB      = 6,
   parameter int          ADC_N       = 4,
   parameter int          TMR_N       = 2,
   localparam int         PU_N        = WIDTH - PU_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_oe,
   output logic [WIDTH-1:0]  pin_out,
   input  logic [PU_N-1:0]   pu_cfg,
   output logic [PU_N-1:0]   pu_en,
   output logic [ADC_N-1:0]  adc_lvl,
   output logic [TMR_N-1:0]  tmr_lvl
);
   if (VAL_ADDR == DIR_ADDR) begin : g_chk_addr
      $error("gpio_dir_port: register addresses collide");
   end
   if (ADDR_W != 4) begin : g_chk_aw
      $error("gpio_dir_port: ADDR_W must match the address parameters");
   end
   if (PU_LSB < 1 || PU_LSB >= WIDTH) begin : g_chk_pu
      $error("gpio_dir_port: PU_LSB out of range");
   end
   if (ADC_N + TMR_N > WIDTH) begin : g_chk_side
      $error("gpio_dir_port: side outputs exceed port width");
   end

   logic             hit_val, hit_dir;
   logic [WIDTH-1:0] val_q, dir_q, lvl;
   rsel_e            rsel;

   assign hit_val = (bus_addr == VAL_ADDR);
   assign hit_dir = (bus_addr == DIR_ADDR);

   always_comb begin
      if (!bus_rd)      rsel = RSEL_NONE;
      else if (hit_val) rsel = RSEL_VAL;
      else if (hit_dir) rsel = RSEL_DIR;
      else              rsel = RSEL_NONE;
   end

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (lvl)
   );

   gpio_regs #(.WIDTH(WIDTH)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .val_we (bus_wr & hit_val),
      .dir_we (bus_wr & hit_dir),
      .wdata  (bus_wdata),
      .val_q  (val_q),
      .dir_q  (dir_q)
   );

   gpio_rdmux #(.WIDTH(WIDTH)) u_rdmux (
      .sel   (rsel),
      .val_q (val_q),
      .dir_q (dir_q),
      .lvl   (lvl),
      .rdata (bus_rdata)
   );

   assign pin_oe  = dir_q;
   assign pin_out = val_q;

   for (genvar k = 0; k < PU_N; k++) begin : g_pu
      assign pu_en[k] = pu_cfg[k] & ~dir_q[PU_LSB + k];
   end

   assign adc_lvl = lvl[ADC_N-1:0];
   assign tmr_lvl = lvl[ADC_N+TMR_N-1:ADC_N];
endmodule

// File: rtl/gpio_dir_port_chk.sv
module gpio_dir_port_chk #(
   parameter int         WIDTH    = 8,
   parameter int         ADDR_W   = 4,
   parameter logic [3:0] VAL_ADDR = 4'h3,
   parameter logic [3:0] DIR_ADDR = 4'h7,
   parameter int         PU_LSB   = 6,
   localparam int        PU_N     = WIDTH - PU_LSB
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [WIDTH-1:0]  bus_wdata,
   input logic [WIDTH-1:0]  bus_rdata,
   input logic [WIDTH-1:0]  pin_oe,
   input logic [WIDTH-1:0]  pin_out,
   input logic [PU_N-1:0]   pu_cfg,
   input logic [PU_N-1:0]   pu_en
);
   // R2
   dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DIR_ADDR) |=> (pin_oe == $past(bus_wdata)));

   // R2
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == DIR_ADDR) |=> $stable(pin_oe));

   // R3
   val_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == VAL_ADDR) |=> (pin_out == $past(bus_wdata)));

   // R3
   val_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == VAL_ADDR) |=> $stable(pin_out));

   // R2
   dir_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == DIR_ADDR) |-> (bus_rdata == pin_oe));

   // R4
   val_read_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == VAL_ADDR) |-> ((bus_rdata & pin_oe) == (pin_out & pin_oe)));

   // R7
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd || (bus_addr != VAL_ADDR && bus_addr != DIR_ADDR)) |-> (bus_rdata == '0));

   // R6
   pullup_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pu_en & ~pu_cfg) == '0 && (pu_en & pin_oe[WIDTH-1:PU_LSB]) == '0);
endmodule

bind gpio_dir_port gpio_dir_port_chk #(
   .WIDTH(WIDTH), .ADDR_W(ADDR_W), .VAL_ADDR(VAL_ADDR),
   .DIR_ADDR(DIR_ADDR), .PU_LSB(PU_LSB)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .pin_oe(pin_oe), .pin_out(pin_out), .pu_cfg(pu_cfg), .pu_en(pu_en)
);

// File: tb/gpio_dir_port_bench.sv
module gpio_dir_port_bench;
   localparam int SEL_RD  = 0;
   localparam int SEL_OE  = 1;
   localparam int SEL_OUT = 2;
   localparam int SEL_PU  = 3;
   localparam int SEL_SIDE = 4;

   typedef struct {
      logic [7:0] exp;
      int         sel;
      string      req;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_oe, pin_out;
   logic [1:0] pu_cfg = '0, pu_en, tmr_lvl;
   logic [3:0] adc_lvl;

   int    checks = 0;
   int    errors = 0;
   item_t sb_q[$];
   event  mon_ev;
   logic [7:0] mdl_val = '0;
   logic [7:0] prev_oe = '0;

   always #5 clk = ~clk;

   gpio_dir_port u_gpio_dir_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
      .pu_cfg(pu_cfg), .pu_en(pu_en), .adc_lvl(adc_lvl), .tmr_lvl(tmr_lvl)
   );

   // monitor: pops expected items and compares with the selected output
   initial begin
      forever begin
         @(mon_ev);
         while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            case (it.sel)
               SEL_RD:  act = bus_rdata;
               SEL_OE:  act = pin_oe;
               SEL_OUT: act = pin_out;
               SEL_PU:  act = {6'd0, pu_en};
               default: act = {2'd0, tmr_lvl, adc_lvl};
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
            end
         end
      end
   end

   // R9: no stale output value when a driver turns on
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         for (int b = 0; b < 8; b++) begin
            if (pin_oe[b] && !prev_oe[b]) begin
               checks++;
               if (pin_out[b] !== mdl_val[b]) begin
                  errors++;
                  $display("FAIL R9 pin %0d: actual %b expected %b", b, pin_out[b], mdl_val[b]);
               end
            end
         end
      end
      prev_oe = pin_oe;
   end

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      if (a == 4'h3) mdl_val = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic expect_sig(input int sel, input logic [7:0] e, input string req);
      item_t it;
      it.exp = e; it.sel = sel; it.req = req;
      sb_q.push_back(it);
      #2 -> mon_ev;
      #1;
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] e, input string req);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      expect_sig(SEL_RD, e, req);
      bus_rd = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      expect_sig(SEL_OE, 8'h00, "R1 oe");
      expect_sig(SEL_OUT, 8'h00, "R1 out");
      rd(4'h7, 8'h00, "R1 dir");
      rd(4'h3, 8'h00, "R1 val");
      // R3 preload while input
      wr(4'h3, 8'hA5);
      expect_sig(SEL_OUT, 8'hA5, "R3 preload");
      expect_sig(SEL_OE, 8'h00, "R3 oe still off");
      // R2 / R9 turn drivers on
      wr(4'h7, 8'hF0);
      expect_sig(SEL_OE, 8'hF0, "R2 oe");
      rd(4'h7, 8'hF0, "R2 dir read");
      // R4 mixed readback
      pin_in = 8'h3C;
      repeat (3) @(negedge clk);
      rd(4'h3, 8'hAC, "R4 mixed");
      // R5 synchronizer depth
      @(negedge clk);
      pin_in = 8'hC3;
      rd(4'h3, 8'hAC, "R5 one edge");
      rd(4'h3, 8'hA3, "R5 two edges");
      // R3 write while output
      wr(4'h3, 8'h5A);
      expect_sig(SEL_OUT, 8'h5A, "R3 write");
      rd(4'h3, 8'h53, "R4 after write");
      // R9 more drivers on
      wr(4'h7, 8'hFF);
      rd(4'h3, 8'h5A, "R4 all out");
      // R6 pull-ups
      pu_cfg = 2'b11;
      expect_sig(SEL_PU, 8'h00, "R6 both out");
      wr(4'h7, 8'h40);
      expect_sig(SEL_PU, 8'h02, "R6 pin7 in");
      wr(4'h7, 8'h00);
      expect_sig(SEL_PU, 8'h03, "R6 both in");
      pu_cfg = 2'b01;
      expect_sig(SEL_PU, 8'h01, "R6 cfg low");
      // R7 unmapped
      rd(4'h5, 8'h00, "R7 unmapped read");
      wr(4'h0, 8'hFF);
      rd(4'h7, 8'h00, "R7 dir untouched");
      expect_sig(SEL_OUT, 8'h5A, "R7 val untouched");
      @(negedge clk);
      bus_addr = 4'h7; bus_rd = 1'b0;
      expect_sig(SEL_RD, 8'h00, "R7 no strobe");
      // R8 side outputs
      pin_in = 8'h5A;
      repeat (2) @(negedge clk);
      expect_sig(SEL_SIDE, 8'h1A, "R8 side");
      rd(4'h3, 8'h5A, "R4 all in");
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule